// File: doc/BRIEF.md
# Serial Bus Status Flag Logic

This block keeps the three ready flags of a byte-oriented serial bus controller. The three flags are transmit-ready, receive-ready and access-ready. The controller datapath reports events as single-cycle strobes:

- the transmit holding register was moved into the shifter;
- the receive shifter was copied into the receive holding register;
- a byte sent from the holding register has finished;
- the data counter has reached zero;
- the register contents have been taken into use.

The CPU side reports three things: writes to the transmit holding register, reads of the receive holding register, and write-one-to-clear accesses to the status word. Every flag has its own rules for setting and clearing. Set and clear requests are resolved in one registered stage, so a flag shows an event on the clock edge after its strobe.

Each flag drives a level interrupt request, gated by a per-flag enable. When the FIFO path is active, the transmit and receive requests are held low. Access-ready is only set in master mode, and its set condition depends on the repeat mode and the stop-request mode bit. When the counter reaches zero and a stop is requested, the block gives a one-cycle stop-request pulse instead of setting the flag.

Flag bit order on `flags`, `irq`, `irq_en` and `cpu_wdata`: bit 0 is access-ready, bit 1 is receive-ready, bit 2 is transmit-ready.

Top module: `serial_status_flags`

## Requirements
- R1: System reset `rst`, and also module reset `soft_rst`, make flags = 3'b100 on the next edge, regardless of any event strobes in that cycle; `stop_req` is 0.
- R2: Transmit-ready (bit 2) goes to 0 the edge after `cpu_tx_wr`, and goes to 1 the edge after `ev_tx_load`.
- R3: A `cpu_w1c` write with `cpu_wdata[2]`=1 leaves transmit-ready unchanged, whether it was 0 or 1.
- R4: Receive-ready (bit 1) goes to 1 after `ev_rx_copy`, and goes to 0 after `cpu_rx_rd` with `cpu_dbg`=0.
- R5: A `cpu_rx_rd` with `cpu_dbg`=1 leaves receive-ready unchanged.
- R6: A `cpu_w1c` write clears each of bit 1 and bit 0 whose `cpu_wdata` bit is 1. A bit written as 0 leaves its flag unchanged.
- R7: In master mode with `mode_repeat`=0 and `mode_stop`=0, `ev_cnt_zero` sets access-ready.
- R8: In master mode with `mode_repeat`=0 and `mode_stop`=1, `ev_cnt_zero` leaves access-ready unchanged. On the next edge `stop_req` goes to 1, for exactly one cycle.
- R9: With `mode_repeat`=1 in master mode, `ev_byte_done` sets access-ready and `ev_cnt_zero` does not.
- R10: Access-ready goes to 0 after `ev_regs_used`, or after a write-one-to-clear of bit 0.
- R11: With `mode_master`=0, no event sets access-ready.
- R12: When a flag gets a set and a clear in the same cycle, it becomes 1.
- R13: `irq[i]` = `flags[i]` & `irq_en[i]`, except that `irq[2]` and `irq[1]` are 0 while `mode_fifo`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | System reset, synchronous, active high |
| soft_rst | input | 1 | Module reset, synchronous, active high |
| ev_tx_load | input | 1 | Transmit holding register moved into shifter |
| ev_rx_copy | input | 1 | Receive shifter copied into holding register |
| ev_byte_done | input | 1 | Byte sent from holding register finished |
| ev_cnt_zero | input | 1 | Data counter reached zero |
| ev_regs_used | input | 1 | Controller took current register contents into use |
| cpu_tx_wr | input | 1 | CPU write of transmit holding register |
| cpu_rx_rd | input | 1 | CPU read of receive holding register |
| cpu_dbg | input | 1 | Marks the current read as a debug access |
| cpu_w1c | input | 1 | Write strobe to the status word |
| cpu_wdata | input | 3 | Write data for the status word |
| mode_master | input | 1 | Master mode |
| mode_repeat | input | 1 | Repeat mode |
| mode_stop | input | 1 | Stop request mode bit |
| mode_fifo | input | 1 | FIFO path active |
| irq_en | input | 3 | Per-flag interrupt enables |
| flags | output | 3 | Ready flags |
| irq | output | 3 | Level interrupt requests |
| stop_req | output | 1 | One-cycle stop request |

## Verification
On every cycle, the assertions check the following:

- set-over-clear priority and holding in each flag cell;
- the forced values after module reset;
- that slave mode never raises access-ready;
- that debug reads and writes to the transmit bit do not disturb their flags;
- that the stop pulse traces back to a zero count with stop requested;
- the FIFO masking of the interrupt requests.

Only the bench scenarios show which mode combination selects which set source. They also show that a flag sets and clears on the expected edge, and that the interrupt levels follow the enables over a sequence of events.

// File: rtl/ssf_pkg.sv
package ssf_pkg;

    localparam int NUM_FLAGS = 3;
    localparam int IDX_ACC   = 0;
    localparam int IDX_RX    = 1;
    localparam int IDX_TX    = 2;

    typedef struct packed {
        logic set;
        logic clr;
    } flag_ctl_t;

    typedef struct packed {
        logic master;
        logic rpt;
        logic stop;
        logic fifo;
    } mode_t;

    function automatic logic flag_reset_value(input int idx);
        return (idx == IDX_TX);
    endfunction

    function automatic logic [NUM_FLAGS-1:0] fifo_mask();
        logic [NUM_FLAGS-1:0] m;
        m = '0;
        m[IDX_TX] = 1'b1;
        m[IDX_RX] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/ssf_flag_cell.sv
module ssf_flag_cell #(
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_any,
    input  logic set,
    input  logic clr,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst_any)
            q <= RESET_VAL;
        else if (set)
            q <= 1'b1;
        else if (clr)
            q <= 1'b0;
    end

    // R12: set request dominates a simultaneous clear
    a_r12_set_wins: assert property (@(posedge clk) disable iff (rst_any)
        set |=> q);

    // R10: a lone clear request drops the flag
    a_r10_clear_only: assert property (@(posedge clk) disable iff (rst_any)
        (clr && !set) |=> !q);

    a_r6_hold_idle: assert property (@(posedge clk) disable iff (rst_any)
        (!set && !clr) |=> $stable(q));

endmodule

// File: rtl/ssf_event_decode.sv
module ssf_event_decode
    import ssf_pkg::*;
(
    input  logic                          ev_tx_load,
    input  logic                          ev_rx_copy,
    input  logic                          ev_byte_done,
    input  logic                          ev_cnt_zero,
    input  logic                          ev_regs_used,
    input  logic                          cpu_tx_wr,
    input  logic                          cpu_rx_rd,
    input  logic                          cpu_dbg,
    input  logic                          cpu_w1c,
    input  logic [NUM_FLAGS-1:0]          cpu_wdata,
    input  mode_t                         mode,
    output flag_ctl_t [NUM_FLAGS-1:0]     ctl,
    output logic                          stop_hit
);

    logic w1c_rx, w1c_acc, cpu_real_rd;
    logic acc_set_rpt, acc_set_cnt;

    assign w1c_rx      = cpu_w1c & cpu_wdata[IDX_RX];
    assign w1c_acc     = cpu_w1c & cpu_wdata[IDX_ACC];
    assign cpu_real_rd = cpu_rx_rd & ~cpu_dbg;

    assign acc_set_rpt = mode.rpt & ev_byte_done;
    assign acc_set_cnt = ~mode.rpt & ~mode.stop & ev_cnt_zero;
    assign stop_hit    = mode.master & ~mode.rpt & mode.stop & ev_cnt_zero;

    always_comb begin
        ctl[IDX_TX].set  = ev_tx_load;
        ctl[IDX_TX].clr  = cpu_tx_wr;
        ctl[IDX_RX].set  = ev_rx_copy;
        ctl[IDX_RX].clr  = cpu_real_rd | w1c_rx;
        ctl[IDX_ACC].set = mode.master & (acc_set_rpt | acc_set_cnt);
        ctl[IDX_ACC].clr = ev_regs_used | w1c_acc;
    end

endmodule

// File: rtl/ssf_irq_gen.sv
module ssf_irq_gen
    import ssf_pkg::*;
(
    input  logic [NUM_FLAGS-1:0] flags,
    input  logic [NUM_FLAGS-1:0] irq_en,
    input  logic                 fifo_on,
    output logic [NUM_FLAGS-1:0] irq
);

    localparam logic [NUM_FLAGS-1:0] MASK = fifo_mask();

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_irq
        if (MASK[i]) begin : g_masked
            assign irq[i] = flags[i] & irq_en[i] & ~fifo_on;
        end else begin : g_plain
            assign irq[i] = flags[i] & irq_en[i];
        end
    end

endmodule

// File: rtl/serial_status_flags.sv
module serial_status_flags
    import ssf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 soft_rst,
    input  logic                 ev_tx_load,
    input  logic                 ev_rx_copy,
    input  logic                 ev_byte_done,
    input  logic                 ev_cnt_zero,
    input  logic                 ev_regs_used,
    input  logic                 cpu_tx_wr,
    input  logic                 cpu_rx_rd,
    input  logic                 cpu_dbg,
    input  logic                 cpu_w1c,
    input  logic [NUM_FLAGS-1:0] cpu_wdata,
    input  logic                 mode_master,
    input  logic                 mode_repeat,
    input  logic                 mode_stop,
    input  logic                 mode_fifo,
    input  logic [NUM_FLAGS-1:0] irq_en,
    output logic [NUM_FLAGS-1:0] flags,
    output logic [NUM_FLAGS-1:0] irq,
    output logic                 stop_req
);

    mode_t                     mode;
    flag_ctl_t [NUM_FLAGS-1:0] ctl;
    logic                      stop_hit;
    logic                      rst_any;

    assign rst_any = rst | soft_rst;
    assign mode    = '{master: mode_master, rpt: mode_repeat,
                       stop: mode_stop, fifo: mode_fifo};

    ssf_event_decode u_decode (
        .ev_tx_load   (ev_tx_load),
        .ev_rx_copy   (ev_rx_copy),
        .ev_byte_done (ev_byte_done),
        .ev_cnt_zero  (ev_cnt_zero),
        .ev_regs_used (ev_regs_used),
        .cpu_tx_wr    (cpu_tx_wr),
        .cpu_rx_rd    (cpu_rx_rd),
        .cpu_dbg      (cpu_dbg),
        .cpu_w1c      (cpu_w1c),
        .cpu_wdata    (cpu_wdata),
        .mode         (mode),
        .ctl          (ctl),
        .stop_hit     (stop_hit)
    );

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        ssf_flag_cell #(.RESET_VAL(flag_reset_value(i))) u_cell (
            .clk     (clk),
            .rst_any (rst_any),
            .set     (ctl[i].set),
            .clr     (ctl[i].clr),
            .q       (flags[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst_any)
            stop_req <= 1'b0;
        else
            stop_req <= stop_hit;
    end

    ssf_irq_gen u_irq (
        .flags   (flags),
        .irq_en  (irq_en),
        .fifo_on (mode_fifo),
        .irq     (irq)
    );

    // R1: module reset forces the documented flag pattern
    a_r1_module_reset: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (flags == 3'b100 && !stop_req));

    // R3: status writes never alter the transmit flag
    a_r3_tx_not_writable: assert property (@(posedge clk) disable iff (rst_any)
        (cpu_w1c && !cpu_tx_wr && !ev_tx_load) |=> $stable(flags[IDX_TX]));

    // R5: debug reads keep receive-ready
    a_r5_debug_read: assert property (@(posedge clk) disable iff (rst_any)
        (cpu_rx_rd && cpu_dbg && !(cpu_w1c && cpu_wdata[IDX_RX]) && flags[IDX_RX])
        |=> flags[IDX_RX]);

    // R11: slave mode never raises access-ready
    a_r11_slave_no_set: assert property (@(posedge clk) disable iff (rst_any)
        (!mode_master && !flags[IDX_ACC]) |=> !flags[IDX_ACC]);

    // R8: stop pulse only follows a zero count with stop requested
    a_r8_stop_source: assert property (@(posedge clk) disable iff (rst_any)
        stop_req |-> $past(ev_cnt_zero && mode_stop && !mode_repeat && mode_master));

    // R13: FIFO mode silences data interrupts
    a_r13_fifo_mask: assert property (@(posedge clk) disable iff (rst)
        mode_fifo |-> (irq[IDX_TX] == 1'b0 && irq[IDX_RX] == 1'b0));

endmodule

// File: tb/serial_status_flags_tb.sv
module serial_status_flags_tb;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst, soft_rst;
    logic       ev_tx_load, ev_rx_copy, ev_byte_done, ev_cnt_zero, ev_regs_used;
    logic       cpu_tx_wr, cpu_rx_rd, cpu_dbg, cpu_w1c;
    logic [2:0] cpu_wdata, irq_en;
    logic       mode_master, mode_repeat, mode_stop, mode_fifo;
    logic [2:0] flags, irq;
    logic       stop_req;

    serial_status_flags u_dut (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .ev_tx_load(ev_tx_load), .ev_rx_copy(ev_rx_copy),
        .ev_byte_done(ev_byte_done), .ev_cnt_zero(ev_cnt_zero),
        .ev_regs_used(ev_regs_used), .cpu_tx_wr(cpu_tx_wr),
        .cpu_rx_rd(cpu_rx_rd), .cpu_dbg(cpu_dbg), .cpu_w1c(cpu_w1c),
        .cpu_wdata(cpu_wdata), .mode_master(mode_master),
        .mode_repeat(mode_repeat), .mode_stop(mode_stop),
        .mode_fifo(mode_fifo), .irq_en(irq_en), .flags(flags),
        .irq(irq), .stop_req(stop_req)
    );

    typedef struct {
        string      tag;
        int         due;
        logic [6:0] exp;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    logic [2:0] m_flags;
    logic       m_stop;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare once outputs have settled after the edge
    always @(posedge clk) begin
        #1;
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            logic [6:0] act;
            it  = q.pop_front();
            act = {stop_req, irq, flags};
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: {stop,irq,flags} got %b expected %b", it.tag, act, it.exp);
            end
        end
    end

    task automatic clear_strobes();
        soft_rst = 0; ev_tx_load = 0; ev_rx_copy = 0; ev_byte_done = 0;
        ev_cnt_zero = 0; ev_regs_used = 0; cpu_tx_wr = 0; cpu_rx_rd = 0;
        cpu_dbg = 0; cpu_w1c = 0; cpu_wdata = '0;
    endtask

    // driver: model the edge from the requirements, queue the result, advance
    task automatic go(input string tag);
        item_t it;
        logic [2:0] irq_e;
        logic s_tx, c_tx, s_rx, c_rx, s_acc, c_acc;
        if (rst || soft_rst) begin
            m_flags = 3'b100;
            m_stop  = 0;
        end else begin
            s_tx  = ev_tx_load;
            c_tx  = cpu_tx_wr;
            s_rx  = ev_rx_copy;
            c_rx  = (cpu_rx_rd && !cpu_dbg) || (cpu_w1c && cpu_wdata[1]);
            s_acc = mode_master && (mode_repeat ? ev_byte_done : (!mode_stop && ev_cnt_zero));
            c_acc = ev_regs_used || (cpu_w1c && cpu_wdata[0]);
            m_flags[2] = s_tx  ? 1'b1 : (c_tx  ? 1'b0 : m_flags[2]);
            m_flags[1] = s_rx  ? 1'b1 : (c_rx  ? 1'b0 : m_flags[1]);
            m_flags[0] = s_acc ? 1'b1 : (c_acc ? 1'b0 : m_flags[0]);
            m_stop = mode_master && !mode_repeat && mode_stop && ev_cnt_zero;
        end
        irq_e = m_flags & irq_en;
        if (mode_fifo) irq_e[2:1] = 2'b00;
        it.tag = tag;
        it.due = cyc + 1;
        it.exp = {m_stop, irq_e, m_flags};
        q.push_back(it);
        @(negedge clk);
        clear_strobes();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_strobes();
        rst = 1; mode_master = 1; mode_repeat = 0; mode_stop = 0; mode_fifo = 0;
        irq_en = 3'b111;
        m_flags = 3'b100; m_stop = 0;
        @(negedge clk);
        go("R1 system reset");
        go("R1 system reset held");
        rst = 0;
        go("R1 idle after reset");

        cpu_tx_wr = 1;                 go("R2 tx write clears");
        ev_tx_load = 1;                go("R2 tx load sets");
        cpu_w1c = 1; cpu_wdata = 3'b100; go("R3 w1c on tx=1");
        cpu_tx_wr = 1;                 go("R2 tx write clears again");
        cpu_w1c = 1; cpu_wdata = 3'b100; go("R3 w1c on tx=0");
        ev_tx_load = 1;                go("R2 restore tx");

        ev_rx_copy = 1;                go("R4 rx copy sets");
        cpu_rx_rd = 1;                 go("R4 rx read clears");
        ev_rx_copy = 1;                go("R4 rx copy again");
        cpu_rx_rd = 1; cpu_dbg = 1;    go("R5 debug read keeps rx");
        cpu_w1c = 1; cpu_wdata = 3'b000; go("R6 w1c zero keeps rx");
        cpu_w1c = 1; cpu_wdata = 3'b010; go("R6 w1c clears rx");

        ev_cnt_zero = 1;               go("R7 count zero sets acc");
        ev_regs_used = 1;              go("R10 regs used clears acc");
        mode_stop = 1;
        ev_cnt_zero = 1;               go("R8 stop mode leaves acc, pulses stop");
        go("R8 stop pulse ends");
        mode_stop = 0; mode_repeat = 1;
        ev_cnt_zero = 1;               go("R9 repeat ignores count zero");
        ev_byte_done = 1;              go("R9 repeat byte done sets acc");
        cpu_w1c = 1; cpu_wdata = 3'b001; go("R10 w1c clears acc");

        mode_master = 0;
        ev_byte_done = 1;              go("R11 slave byte done ignored");
        mode_repeat = 0;
        ev_cnt_zero = 1;               go("R11 slave count zero ignored");
        mode_master = 1;

        cpu_tx_wr = 1;                 go("R12 prep tx clear");
        cpu_tx_wr = 1; ev_tx_load = 1; go("R12 tx set beats clear");
        ev_rx_copy = 1; cpu_rx_rd = 1; go("R12 rx set beats clear");
        ev_cnt_zero = 1; ev_regs_used = 1; go("R12 acc set beats clear");

        irq_en = 3'b101;               go("R13 enables mask rx irq");
        mode_fifo = 1; irq_en = 3'b111; go("R13 fifo masks tx rx irq");
        irq_en = 3'b000; mode_fifo = 0; go("R13 all disabled");
        irq_en = 3'b111;               go("R13 all enabled");

        soft_rst = 1; ev_rx_copy = 1; ev_cnt_zero = 1; go("R1 module reset overrides events");
        go("R1 after module reset");

        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule